// File: doc/BRIEF.md
# Coalescing Store Cache for Stratum Execution

This block sits beside a core and takes the place of a first-in first-out store buffer. While a stratum executes, every store the core retires is written into a small set-associative array instead of a queue. A store to a word that is already held merges into that entry byte by byte under a write mask. The order in which stores arrived is thrown away. Loads from the same core look the array up and see their own buffered bytes.

When the stratum controller pulses the publish start input, the block stops taking stores. It then streams every held entry out on a valid/ready drain port, one entry per accepted beat. When nothing is left, it raises a one-cycle done pulse and returns empty and ready for the next stratum.

A store can miss into a set whose ways are all taken. The overflow mode input then picks what happens. In bounded mode the store is refused and a sticky overflow flag asks the controller to end the stratum. In unbounded mode a round-robin victim is pushed out on a log port and the new word takes its place.

Top module: `scache_top`

## Requirements
- R1: After reset the cache is empty. Loads miss, `drn_valid_o`, `pub_done_o`, `ovf_o` and `log_valid_o` are low, and `st_ready_o` is high.
- R2: A load lookup is combinational. On a hit it returns the buffered word and its byte mask. On a miss it returns hit 0, data 0 and mask 0. Bytes the core never wrote read as 0.
- R3: A store to a word address already held merges into that entry. Bytes whose mask bit is set take the new value, the other bytes keep theirs, and the mask becomes the OR of both. The word still occupies one entry and drains as one beat.
- R4: Address bits [2:0] select one of 8 sets and the remaining bits form the tag. Each set holds 8 distinct words, and a store that hits a full set is always accepted.
- R5: With `mode_i`=0, a store that misses a full set is refused (`st_ready_o` low) and leaves the contents unchanged. `ovf_o` rises on the next cycle and stays high until the next publish completes.
- R6: With `mode_i`=1, a store that misses a full set is accepted into the set's victim way. Victims rotate per set starting at way 0, and a new word takes the lowest free way. On the following cycle `log_valid_o` pulses for one cycle carrying the evicted word's address, data and mask.
- R7: A `pub_start_i` pulse while idle starts a publish. From the next cycle, entries drain one per `drn_valid_o`&`drn_ready_i` beat in ascending order of set*8+way.
- R8: While `drn_valid_o` is high and `drn_ready_i` is low, the drain address, data and mask hold steady.
- R9: During a publish `st_ready_o` is low. `pub_done_o` is high for exactly one cycle once no entries remain. On the next cycle all loads miss and stores are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Overflow policy: 0 end stratum, 1 spill to log |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data |
| st_mask_i | input | DATA_W/8 | Store byte enables |
| ld_addr_i | input | ADDR_W | Load lookup word address |
| ld_hit_o | output | 1 | Lookup hit |
| ld_data_o | output | DATA_W | Buffered data on hit |
| ld_mask_o | output | DATA_W/8 | Buffered byte mask on hit |
| pub_start_i | input | 1 | Begin publish |
| pub_done_o | output | 1 | Publish finished, one-cycle pulse |
| drn_valid_o | output | 1 | Drain entry valid |
| drn_ready_i | input | 1 | Drain entry taken |
| drn_addr_o | output | ADDR_W | Drain word address |
| drn_data_o | output | DATA_W | Drain data |
| drn_mask_o | output | DATA_W/8 | Drain byte mask |
| ovf_o | output | 1 | Resource exhaustion, sticky until publish done |
| log_valid_o | output | 1 | Spilled entry valid |
| log_addr_o | output | ADDR_W | Spilled word address |
| log_data_o | output | DATA_W | Spilled data |
| log_mask_o | output | DATA_W/8 | Spilled byte mask |

## Verification
Directed patterns come first. Disjoint masks on one word separate true byte merging from whole-word overwrite. Filling one set to exactly eight words, then adding a ninth, separates bounded refusal from unbounded spill and shows whether the victim rotates or sticks at one way. Random stores then draw tags from a small pool, so hits, fresh allocations and full-set misses mix in both modes. Drains run under a random ready to show the ascending flat-index order, and that the output holds while a beat is stalled.

// File: rtl/scache_pkg.sv
package scache_pkg;
  typedef enum logic {
    MODE_BOUNDED   = 1'b0,
    MODE_UNBOUNDED = 1'b1
  } ovf_mode_e;
endpackage

// File: rtl/scache_set.sv
module scache_set #(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [TAG_W-1:0]        st_tag_i,
  input  logic [DATA_W-1:0]       st_data_i,
  input  logic [DATA_W/8-1:0]     st_mask_i,
  output logic                    st_hit_o,
  output logic                    st_full_o,
  output logic                    ev_valid_o,
  output logic [TAG_W-1:0]        ev_tag_o,
  output logic [DATA_W-1:0]       ev_data_o,
  output logic [DATA_W/8-1:0]     ev_mask_o,
  input  logic [TAG_W-1:0]        ld_tag_i,
  output logic                    ld_hit_o,
  output logic [DATA_W-1:0]       ld_data_o,
  output logic [DATA_W/8-1:0]     ld_mask_o,
  input  logic                    clr_en_i,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] clr_way_i,
  output logic [WAYS-1:0]         vld_o,
  output logic [WAYS*TAG_W-1:0]   tag_o,
  output logic [WAYS*DATA_W-1:0]  data_o,
  output logic [WAYS*DATA_W/8-1:0] mask_o
);
  localparam int BE_W  = DATA_W / 8;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [WAYS];
  logic [DATA_W-1:0] data_q [WAYS];
  logic [BE_W-1:0]   mask_q [WAYS];
  logic [WAY_W-1:0]  vic_q;

  logic              hit, free_any, ld_hit;
  logic [WAY_W-1:0]  hit_way, free_way, ld_way, tgt_way;
  logic [DATA_W-1:0] st_bm, merged;
  logic              replace;

  // lowest matching/free way wins
  always_comb begin
    hit = 1'b0; hit_way = '0;
    free_any = 1'b0; free_way = '0;
    ld_hit = 1'b0; ld_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[w] && tag_q[w] == st_tag_i) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!vld_q[w]) begin
        free_any = 1'b1; free_way = WAY_W'(w);
      end
      if (vld_q[w] && tag_q[w] == ld_tag_i) begin
        ld_hit = 1'b1; ld_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BE_W; b++) st_bm[b*8 +: 8] = {8{st_mask_i[b]}};
  end

  assign merged  = (data_q[hit_way] & ~st_bm) | (st_data_i & st_bm);
  assign tgt_way = hit ? hit_way : (free_any ? free_way : vic_q);
  assign replace = wr_en_i && !hit && !free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      vic_q <= '0;
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w]  <= '0;
        data_q[w] <= '0;
        mask_q[w] <= '0;
      end
    end else begin
      if (clr_en_i) vld_q[clr_way_i] <= 1'b0;
      if (wr_en_i) begin
        vld_q[tgt_way] <= 1'b1;
        tag_q[tgt_way] <= st_tag_i;
        if (hit) begin
          data_q[tgt_way] <= merged;
          mask_q[tgt_way] <= mask_q[hit_way] | st_mask_i;
        end else begin
          data_q[tgt_way] <= st_data_i & st_bm;
          mask_q[tgt_way] <= st_mask_i;
        end
      end
      if (replace) vic_q <= vic_q + WAY_W'(1);
    end
  end

  assign st_hit_o   = hit;
  assign st_full_o  = &vld_q;
  assign ev_valid_o = replace;
  assign ev_tag_o   = tag_q[vic_q];
  assign ev_data_o  = data_q[vic_q];
  assign ev_mask_o  = mask_q[vic_q];
  assign ld_hit_o   = ld_hit;
  assign ld_data_o  = ld_hit ? data_q[ld_way] : '0;
  assign ld_mask_o  = ld_hit ? mask_q[ld_way] : '0;
  assign vld_o      = vld_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_flat
    assign tag_o[w*TAG_W +: TAG_W]    = tag_q[w];
    assign data_o[w*DATA_W +: DATA_W] = data_q[w];
    assign mask_o[w*BE_W +: BE_W]     = mask_q[w];
  end
endmodule

// File: rtl/scache_pick.sv
module scache_pick #(
  parameter int N = 64
) (
  input  logic [N-1:0]                      vld_i,
  output logic                              any_o,
  output logic [((N>1)?$clog2(N):1)-1:0]    idx_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/scache_top.sv
module scache_top
  import scache_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 64,
  parameter int WAYS    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                st_valid_i,
  output logic                st_ready_o,
  input  logic [ADDR_W-1:0]   st_addr_i,
  input  logic [DATA_W-1:0]   st_data_i,
  input  logic [DATA_W/8-1:0] st_mask_i,
  input  logic [ADDR_W-1:0]   ld_addr_i,
  output logic                ld_hit_o,
  output logic [DATA_W-1:0]   ld_data_o,
  output logic [DATA_W/8-1:0] ld_mask_o,
  input  logic                pub_start_i,
  output logic                pub_done_o,
  output logic                drn_valid_o,
  input  logic                drn_ready_i,
  output logic [ADDR_W-1:0]   drn_addr_o,
  output logic [DATA_W-1:0]   drn_data_o,
  output logic [DATA_W/8-1:0] drn_mask_o,
  output logic                ovf_o,
  output logic                log_valid_o,
  output logic [ADDR_W-1:0]   log_addr_o,
  output logic [DATA_W-1:0]   log_data_o,
  output logic [DATA_W/8-1:0] log_mask_o
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int BE_W  = DATA_W / 8;

  logic [SET_W-1:0] st_set, ld_set, pk_set;
  logic [TAG_W-1:0] st_tag, ld_tag;
  logic [WAY_W-1:0] pk_way;
  logic [ENT_W-1:0] pk_idx;
  logic             pk_any;

  logic              set_hit  [SETS];
  logic              set_full [SETS];
  logic              set_ev   [SETS];
  logic [TAG_W-1:0]  set_evt  [SETS];
  logic [DATA_W-1:0] set_evd  [SETS];
  logic [BE_W-1:0]   set_evm  [SETS];
  logic              set_lh   [SETS];
  logic [DATA_W-1:0] set_ld   [SETS];
  logic [BE_W-1:0]   set_lm   [SETS];

  logic [ENTRIES-1:0]        all_vld;
  logic [ENTRIES*TAG_W-1:0]  all_tag;
  logic [ENTRIES*DATA_W-1:0] all_data;
  logic [ENTRIES*BE_W-1:0]   all_mask;

  logic pub_active_q, ovf_q;
  logic log_valid_q;
  logic [ADDR_W-1:0] log_addr_q;
  logic [DATA_W-1:0] log_data_q;
  logic [BE_W-1:0]   log_mask_q;

  logic bounded, full_miss, st_acc, drn_fire, pub_done;

  assign st_set = st_addr_i[SET_W-1:0];
  assign st_tag = st_addr_i[ADDR_W-1:SET_W];
  assign ld_set = ld_addr_i[SET_W-1:0];
  assign ld_tag = ld_addr_i[ADDR_W-1:SET_W];

  assign bounded    = (ovf_mode_e'(mode_i) == MODE_BOUNDED);
  assign full_miss  = set_full[st_set] && !set_hit[st_set];
  assign st_ready_o = !pub_active_q && !(full_miss && bounded);
  assign st_acc     = st_valid_i && st_ready_o;

  assign pk_set   = pk_idx[ENT_W-1:WAY_W];
  assign pk_way   = pk_idx[WAY_W-1:0];
  assign drn_valid_o = pub_active_q && pk_any;
  assign drn_fire = drn_valid_o && drn_ready_i;
  assign pub_done = pub_active_q && !pk_any;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    scache_set #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (st_acc && (st_set == SET_W'(s))),
      .st_tag_i   (st_tag),
      .st_data_i  (st_data_i),
      .st_mask_i  (st_mask_i),
      .st_hit_o   (set_hit[s]),
      .st_full_o  (set_full[s]),
      .ev_valid_o (set_ev[s]),
      .ev_tag_o   (set_evt[s]),
      .ev_data_o  (set_evd[s]),
      .ev_mask_o  (set_evm[s]),
      .ld_tag_i   (ld_tag),
      .ld_hit_o   (set_lh[s]),
      .ld_data_o  (set_ld[s]),
      .ld_mask_o  (set_lm[s]),
      .clr_en_i   (drn_fire && (pk_set == SET_W'(s))),
      .clr_way_i  (pk_way),
      .vld_o      (all_vld[s*WAYS +: WAYS]),
      .tag_o      (all_tag[s*WAYS*TAG_W +: WAYS*TAG_W]),
      .data_o     (all_data[s*WAYS*DATA_W +: WAYS*DATA_W]),
      .mask_o     (all_mask[s*WAYS*BE_W +: WAYS*BE_W])
    );
  end

  scache_pick #(.N(ENTRIES)) u_pick (
    .vld_i (all_vld),
    .any_o (pk_any),
    .idx_o (pk_idx)
  );

  assign drn_addr_o = {all_tag[pk_idx*TAG_W +: TAG_W], pk_set};
  assign drn_data_o = all_data[pk_idx*DATA_W +: DATA_W];
  assign drn_mask_o = all_mask[pk_idx*BE_W +: BE_W];
  assign pub_done_o = pub_done;

  assign ld_hit_o  = set_lh[ld_set];
  assign ld_data_o = set_ld[ld_set];
  assign ld_mask_o = set_lm[ld_set];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pub_active_q <= 1'b0;
      ovf_q        <= 1'b0;
      log_valid_q  <= 1'b0;
      log_addr_q   <= '0;
      log_data_q   <= '0;
      log_mask_q   <= '0;
    end else begin
      if (!pub_active_q && pub_start_i) pub_active_q <= 1'b1;
      else if (pub_done)                pub_active_q <= 1'b0;

      if (pub_done) ovf_q <= 1'b0;
      else if (st_valid_i && !pub_active_q && full_miss && bounded) ovf_q <= 1'b1;

      log_valid_q <= set_ev[st_set];
      if (set_ev[st_set]) begin
        log_addr_q <= {set_evt[st_set], st_set};
        log_data_q <= set_evd[st_set];
        log_mask_q <= set_evm[st_set];
      end
    end
  end

  assign ovf_o       = ovf_q;
  assign log_valid_o = log_valid_q;
  assign log_addr_o  = log_addr_q;
  assign log_data_o  = log_data_q;
  assign log_mask_o  = log_mask_q;
endmodule

// File: rtl/scache_chk.sv
module scache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mode_i,
  input logic                st_valid_i,
  input logic                st_ready_o,
  input logic                pub_active,
  input logic                pub_done_o,
  input logic                drn_valid_o,
  input logic                drn_ready_i,
  input logic [ADDR_W-1:0]   drn_addr_o,
  input logic [DATA_W-1:0]   drn_data_o,
  input logic [DATA_W/8-1:0] drn_mask_o,
  input logic                ld_hit_o,
  input logic                ovf_o,
  input logic                log_valid_o
);
  a_r9_no_store_in_pub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pub_active |-> !st_ready_o);

  a_r7_drain_in_pub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drn_valid_o |-> pub_active);

  a_r8_drain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drn_valid_o && !drn_ready_i |=> drn_valid_o && $stable(drn_addr_o)
      && $stable(drn_data_o) && $stable(drn_mask_o));

  a_r9_done_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pub_done_o |=> !ld_hit_o && !pub_active && !pub_done_o && !ovf_o);

  a_r5_refuse_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && !st_ready_o && !pub_active |=> ovf_o);

  a_r6_log_unbounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_valid_o |-> $past(mode_i));
endmodule

bind scache_top scache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .st_valid_i  (st_valid_i),
  .st_ready_o  (st_ready_o),
  .pub_active  (pub_active_q),
  .pub_done_o  (pub_done_o),
  .drn_valid_o (drn_valid_o),
  .drn_ready_i (drn_ready_i),
  .drn_addr_o  (drn_addr_o),
  .drn_data_o  (drn_data_o),
  .drn_mask_o  (drn_mask_o),
  .ld_hit_o    (ld_hit_o),
  .ovf_o       (ovf_o),
  .log_valid_o (log_valid_o)
);

// File: tb/sim_scache_top.sv
`timescale 1ns/1ps
module sim_scache_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [15:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_mask = '0;
  logic [15:0] ld_addr = '0;
  logic        ld_hit;
  logic [31:0] ld_data;
  logic [3:0]  ld_mask;
  logic        pub_start = 1'b0;
  logic        pub_done;
  logic        drn_valid;
  logic        drn_ready = 1'b0;
  logic [15:0] drn_addr;
  logic [31:0] drn_data;
  logic [3:0]  drn_mask;
  logic        ovf;
  logic        log_valid;
  logic [15:0] log_addr;
  logic [31:0] log_data;
  logic [3:0]  log_mask;

  always #10 clk = ~clk;

  scache_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_mask_i(st_mask),
    .ld_addr_i(ld_addr), .ld_hit_o(ld_hit), .ld_data_o(ld_data), .ld_mask_o(ld_mask),
    .pub_start_i(pub_start), .pub_done_o(pub_done),
    .drn_valid_o(drn_valid), .drn_ready_i(drn_ready), .drn_addr_o(drn_addr),
    .drn_data_o(drn_data), .drn_mask_o(drn_mask),
    .ovf_o(ovf), .log_valid_o(log_valid), .log_addr_o(log_addr),
    .log_data_o(log_data), .log_mask_o(log_mask)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  // reference model: 8 sets x 8 ways
  bit          m_vld  [8][8];
  int          m_tag  [8][8];
  logic [31:0] m_data [8][8];
  logic [3:0]  m_mask [8][8];
  int          m_vic  [8];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] m);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic int find_hit(int s, int t);
    for (int w = 0; w < 8; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int find_free(int s);
    for (int w = 0; w < 8; w++) if (!m_vld[s][w]) return w;
    return -1;
  endfunction

  function automatic bit model_empty();
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 8; w++) if (m_vld[s][w]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_store(input logic [15:0] a, input logic [31:0] d,
                          input logic [3:0] m, input string req);
    int s, t, h, f, v;
    bit acc, spill;
    logic [15:0] ev_a;
    logic [31:0] ev_d;
    logic [3:0]  ev_m;
    s = int'(a[2:0]); t = int'(a[15:3]);
    h = find_hit(s, t); f = find_free(s);
    acc = (h >= 0) || (f >= 0) || mode;
    spill = (h < 0) && (f < 0) && mode;
    v = m_vic[s];
    ev_a = {13'(m_tag[s][v]), 3'(s)}; ev_d = m_data[s][v]; ev_m = m_mask[s][v];
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
    #1 check(req, "st_ready", st_ready, acc);
    @(posedge clk);
    if (acc) begin
      if (h >= 0) begin
        m_data[s][h] = merge(m_data[s][h], d, m);
        m_mask[s][h] = m_mask[s][h] | m;
      end else begin
        int w = (f >= 0) ? f : v;
        m_vld[s][w] = 1'b1; m_tag[s][w] = t;
        m_data[s][w] = merge(32'h0, d, m); m_mask[s][w] = m;
        if (f < 0) m_vic[s] = (v + 1) % 8;
      end
    end
    @(negedge clk);
    st_valid = 1'b0;
    #1 check("R6", "log_valid", log_valid, spill);
    if (spill) begin
      check("R6", "log_addr", log_addr, ev_a);
      check("R6", "log_data", log_data, ev_d);
      check("R6", "log_mask", log_mask, ev_m);
    end
  endtask

  task automatic chk_ld(input logic [15:0] a, input string req);
    int s, t, h;
    s = int'(a[2:0]); t = int'(a[15:3]); h = find_hit(s, t);
    @(negedge clk);
    ld_addr = a;
    #1;
    check(req, "ld_hit", ld_hit, h >= 0);
    check(req, "ld_data", ld_data, (h >= 0) ? m_data[s][h] : 32'h0);
    check(req, "ld_mask", ld_mask, (h >= 0) ? m_mask[s][h] : 4'h0);
  endtask

  task automatic pub_run(input bit rnd_ready);
    bit prev_stall = 1'b0;
    bit fin = 1'b0;
    @(negedge clk);
    pub_start = 1'b1;
    @(negedge clk);
    pub_start = 1'b0;
    for (int it = 0; it < 3000 && !fin; it++) begin
      int fs = -1, fw = -1;
      drn_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
      #1;
      check("R9", "st_ready in publish", st_ready, 1'b0);
      for (int s = 0; s < 8 && fs < 0; s++)
        for (int w = 0; w < 8 && fs < 0; w++)
          if (m_vld[s][w]) begin fs = s; fw = w; end
      if (fs >= 0) begin
        string rq = prev_stall ? "R8" : "R7";
        check(rq, "drn_valid", drn_valid, 1'b1);
        check(rq, "drn_addr", drn_addr, {13'(m_tag[fs][fw]), 3'(fs)});
        check(rq, "drn_data", drn_data, m_data[fs][fw]);
        check(rq, "drn_mask", drn_mask, m_mask[fs][fw]);
        if (drn_ready) m_vld[fs][fw] = 1'b0;
        prev_stall = !drn_ready;
      end else begin
        check("R9", "drn_valid at end", drn_valid, 1'b0);
        check("R9", "pub_done", pub_done, 1'b1);
        fin = 1'b1;
      end
      @(negedge clk);
    end
    drn_ready = 1'b0;
    #1;
    check("R9", "pub_done one cycle", pub_done, 1'b0);
    check("R9", "st_ready after publish", st_ready, 1'b1);
    check("R5", "ovf cleared by publish", ovf, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_f) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 8; s++) begin
      m_vic[s] = 0;
      for (int w = 0; w < 8; w++) begin
        m_vld[s][w] = 0; m_tag[s][w] = 0; m_data[s][w] = '0; m_mask[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "ld_hit", ld_hit, 1'b0);
    check("R1", "drn_valid", drn_valid, 1'b0);
    check("R1", "pub_done", pub_done, 1'b0);
    check("R1", "ovf", ovf, 1'b0);
    check("R1", "log_valid", log_valid, 1'b0);
    check("R1", "st_ready", st_ready, 1'b1);

    // R2 forwarding
    mode = 1'b0;
    do_store(16'h0010, 32'hAABBCCDD, 4'hF, "R2");
    chk_ld(16'h0010, "R2");
    chk_ld(16'h0018, "R2");
    do_store(16'h0031, 32'h12345678, 4'b0101, "R2");
    chk_ld(16'h0031, "R2");

    // R3 coalescing
    do_store(16'h0021, 32'h11112222, 4'b0011, "R3");
    do_store(16'h0021, 32'h33334444, 4'b0110, "R3");
    chk_ld(16'h0021, "R3");
    check("R3", "merged value", ld_data, 32'h00334422);
    check("R3", "merged mask", ld_mask, 4'b0111);
    pub_run(1'b0);

    // R4/R5 bounded: fill set 5
    for (int i = 0; i < 8; i++) do_store(16'((i + 1) * 8 + 5), 32'hA000_0000 + 32'(i), 4'hF, "R4");
    for (int i = 0; i < 8; i++) chk_ld(16'((i + 1) * 8 + 5), "R4");
    do_store(16'(9 * 8 + 5), 32'hDEAD_BEEF, 4'hF, "R5");
    #1 check("R5", "ovf raised", ovf, 1'b1);
    chk_ld(16'(9 * 8 + 5), "R5");
    do_store(16'(3 * 8 + 5), 32'h0000_FF00, 4'b0010, "R4");
    chk_ld(16'(3 * 8 + 5), "R4");
    check("R5", "ovf sticky", ovf, 1'b1);
    pub_run(1'b1);
    chk_ld(16'(3 * 8 + 5), "R9");

    // R6 unbounded spill on set 3
    mode = 1'b1;
    for (int i = 0; i < 8; i++) do_store(16'((i + 2) * 8 + 3), 32'hB000_0000 + 32'(i), 4'hF, "R6");
    do_store(16'(20 * 8 + 3), 32'hC0DE_0001, 4'b1001, "R6");
    do_store(16'(21 * 8 + 3), 32'hC0DE_0002, 4'hF, "R6");
    chk_ld(16'(2 * 8 + 3), "R6");
    chk_ld(16'(3 * 8 + 3), "R6");
    chk_ld(16'(20 * 8 + 3), "R6");
    check("R6", "ovf stays low", ovf, 1'b0);
    pub_run(1'b1);

    // random rounds
    for (int r = 0; r < 4; r++) begin
      mode = (r != 2);
      for (int k = 0; k < 250; k++) begin
        logic [15:0] a = {13'($urandom % 11), 3'($urandom % 8)};
        logic [3:0]  m = 4'($urandom % 15) + 4'd1;
        do_store(a, $urandom, m, mode ? "R6" : "R5");
        if (k % 5 == 0) chk_ld({13'($urandom % 11), 3'($urandom % 8)}, "R2");
      end
      pub_run(1'b1);
      check("R9", "model drained", model_empty(), 1'b1);
    end

    done_f = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule